// File: doc/BRIEF.md
# DMA Channel Address Register Bank with Region and Alignment Checks

This block holds the source and destination byte-address registers of four DMA channels behind a small memory-mapped register bus. Each bus access carries an address, write data, an access size and a read/write select, and gets its error response in the same cycle. Writes are screened against size rules. Source registers take byte, halfword or word writes merged by byte lane. Destination registers take only full-word writes.

The upper twelve bits of every address must hold one of four region codes. A write with any other code is still accepted, but the register is marked invalid. Reads of an invalid register return zero in the upper field. Nothing is reported until the channel is told to start. On a start pulse the channel raises a sticky configuration-error flag if either address is in a bad region or is not naturally aligned to its programmed transfer size. A per-channel clear strobe removes the flag. The block also gives the channel engine the stored addresses and a live misalignment indication.

Top module: `dma_addr_bank`

## Requirements
- R1: After reset every source and destination address register reads zero, and every configuration-error flag is low.
- R2: Channel i's source register sits at 0x4000_8100 + 16*i and its destination register at 0x4000_8104 + 16*i. Offsets +8 and +0xC inside a channel slot, and any address outside the 64-byte window, give a bus error.
- R3: A destination write with size code 0 (byte) or 1 (halfword) gives a bus error in the same cycle and leaves the register unchanged.
- R4: Source writes use size code 0 (byte, lane addr[1:0]), code 1 (halfword, lanes selected by addr[1]) or code 2 (word). Only the addressed bytes change, taken from the matching bus data lanes. Size code 3, a halfword at an odd address, or a word at a nonzero addr[1:0] gives a bus error and changes nothing.
- R5: When bits 31..20 of a register hold 0x000, 0x1FF, 0x200 or 0x400, a read returns the full stored value.
- R6: A write that leaves any other value in bits 31..20 raises no bus error. The channel output carries the stored value, and a read returns zero in bits 31..20 with bits 19..0 intact.
- R7: A start pulse on a channel sets its error flag one cycle later if either of its addresses holds a non-permitted upper field. A channel whose addresses are both permitted and aligned keeps its flag low.
- R8: Transfer size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved (always misaligned). The misalignment output for a channel is high in the same cycle whenever the source or the destination address is not a multiple of its size. A start pulse with either address misaligned sets the error flag.
- R9: The error flag is sticky and clears one cycle after a clear strobe. If start and clear come together and a fault is present, the flag ends up set.
- R10: An accepted write is visible on the channel address outputs and in reads from the next cycle on. Bus error and read data answer in the cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, lane-aligned |
| bus_rdata | output | 32 | Read data, zero unless a good read |
| bus_err | output | 1 | Error response, same cycle as bus_sel |
| ch_start | input | 4 | Per-channel start pulse |
| ch_err_clr | input | 4 | Per-channel error-flag clear |
| ch_src_size | input | 8 | Source transfer size code, 2 bits per channel |
| ch_dst_size | input | 8 | Destination transfer size code, 2 bits per channel |
| ch_src_addr | output | 128 | Stored source addresses, 32 bits per channel |
| ch_dst_addr | output | 128 | Stored destination addresses, 32 bits per channel |
| ch_misalign | output | 4 | Per-channel misalignment indication |
| ch_cfg_err | output | 4 | Per-channel sticky configuration error |

## Verification
Bus error and read data are combinational, so their expected values are due in the access cycle itself. Register contents and error flags are registered, so they are due one cycle after the write, start or clear. The misalignment output follows the stored addresses and size codes without delay. Each driver task stamps every expected item with the cycle number in which it is due. A monitor samples at the falling edge and compares only the items stamped for the current cycle, so each result is checked in exactly the cycle the requirements place it.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

  localparam int ADDR_W = 32;
  localparam int UP_LSB = 20;
  localparam int UP_W   = ADDR_W - UP_LSB;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_sz_e;

  localparam logic [UP_W-1:0] RGN_LOW  = 12'h000;
  localparam logic [UP_W-1:0] RGN_ALIAS = 12'h1FF;
  localparam logic [UP_W-1:0] RGN_SRAM = 12'h200;
  localparam logic [UP_W-1:0] RGN_PERI = 12'h400;

  function automatic logic region_ok(input logic [UP_W-1:0] up);
    return (up == RGN_LOW) || (up == RGN_ALIAS) ||
           (up == RGN_SRAM) || (up == RGN_PERI);
  endfunction

  function automatic logic misaligned(input logic [1:0] lo, input logic [1:0] sz);
    logic r;
    case (sz)
      SZ_BYTE: r = 1'b0;
      SZ_HALF: r = lo[0];
      SZ_WORD: r = |lo;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dma_region_chk.sv
module dma_region_chk
  import dma_addr_pkg::*;
(
  input  logic [UP_W-1:0] upper,
  output logic            bad
);
  assign bad = !region_ok(upper);
endmodule

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
  import dma_addr_pkg::*;
#(
  parameter int          NUM_CH = 4,
  parameter logic [31:0] BASE   = 32'h4000_8100,
  localparam int         CHW    = $clog2(NUM_CH),
  localparam int         OFF_W  = 4 + CHW
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [31:0]       bus_addr,
  input  logic [1:0]        bus_size,
  output logic [NUM_CH-1:0] src_we,
  output logic [NUM_CH-1:0] dst_we,
  output logic [3:0]        byte_en,
  output logic              rd_valid,
  output logic              rd_dst,
  output logic [CHW-1:0]    rd_ch,
  output logic              bus_err
);
  logic           blk_hit, reg_hit, size_bad, dst_narrow, wr_ok;
  logic [1:0]     lane, reg_sel;
  logic [CHW-1:0] ch;

  assign blk_hit    = bus_addr[31:OFF_W] == BASE[31:OFF_W];
  assign ch         = bus_addr[OFF_W-1:4];
  assign reg_sel    = bus_addr[3:2];
  assign lane       = bus_addr[1:0];
  assign reg_hit    = blk_hit && !reg_sel[1];
  assign size_bad   = (bus_size == SZ_RSVD) ||
                      (bus_size == SZ_HALF && lane[0]) ||
                      (bus_size == SZ_WORD && lane != 2'd0);
  assign dst_narrow = bus_wr && reg_sel[0] && (bus_size != SZ_WORD);
  assign bus_err    = bus_sel && (!reg_hit || size_bad || dst_narrow);
  assign wr_ok      = bus_sel && bus_wr && !bus_err;
  assign rd_valid   = bus_sel && !bus_wr && !bus_err;
  assign rd_dst     = reg_sel[0];
  assign rd_ch      = ch;

  always_comb begin
    case (bus_size)
      SZ_BYTE: byte_en = 4'b0001 << lane;
      SZ_HALF: byte_en = lane[1] ? 4'b1100 : 4'b0011;
      default: byte_en = 4'b1111;
    endcase
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_we
    assign src_we[i] = wr_ok && !reg_sel[0] && (ch == CHW'(i));
    assign dst_we[i] = wr_ok &&  reg_sel[0] && (ch == CHW'(i));
  end
endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
  import dma_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_we,
  input  logic              dst_we,
  input  logic [3:0]        byte_en,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              start,
  input  logic              err_clr,
  input  logic [1:0]        src_sz,
  input  logic [1:0]        dst_sz,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic              src_bad,
  output logic              dst_bad,
  output logic              misalign,
  output logic              cfg_err
);
  logic [ADDR_W-1:0] src_d;
  logic              cfg_d, fault;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign src_d[8*k +: 8] = byte_en[k] ? wdata[8*k +: 8] : src_q[8*k +: 8];
  end

  dma_region_chk u_src_rgn (.upper(src_q[ADDR_W-1:UP_LSB]), .bad(src_bad));
  dma_region_chk u_dst_rgn (.upper(dst_q[ADDR_W-1:UP_LSB]), .bad(dst_bad));

  assign misalign = misaligned(src_q[1:0], src_sz) || misaligned(dst_q[1:0], dst_sz);
  assign fault    = src_bad || dst_bad || misalign;

  always_comb begin
    cfg_d = err_clr ? 1'b0 : cfg_err;
    if (start && fault) cfg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_we) src_q <= src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (dst_we) dst_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cfg_err <= 1'b0;
    else if (start || err_clr)   cfg_err <= cfg_d;
  end
endmodule

// File: rtl/dma_addr_bank.sv
module dma_addr_bank
  import dma_addr_pkg::*;
#(
  parameter int          NUM_CH = 4,
  parameter logic [31:0] BASE   = 32'h4000_8100,
  localparam int         CHW    = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [31:0]              bus_addr,
  input  logic [1:0]               bus_size,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_err,
  input  logic [NUM_CH-1:0]        ch_start,
  input  logic [NUM_CH-1:0]        ch_err_clr,
  input  logic [2*NUM_CH-1:0]      ch_src_size,
  input  logic [2*NUM_CH-1:0]      ch_dst_size,
  output logic [ADDR_W*NUM_CH-1:0] ch_src_addr,
  output logic [ADDR_W*NUM_CH-1:0] ch_dst_addr,
  output logic [NUM_CH-1:0]        ch_misalign,
  output logic [NUM_CH-1:0]        ch_cfg_err
);
  logic              rst_n_i;
  logic [NUM_CH-1:0] src_we, dst_we, src_bad, dst_bad;
  logic [3:0]        byte_en;
  logic              rd_valid, rd_dst;
  logic [CHW-1:0]    rd_ch;
  logic [ADDR_W-1:0] src_q [NUM_CH];
  logic [ADDR_W-1:0] dst_q [NUM_CH];
  logic [ADDR_W-1:0] rd_word;
  logic              rd_bad;

  dma_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  dma_addr_decode #(.NUM_CH(NUM_CH), .BASE(BASE)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .src_we(src_we), .dst_we(dst_we), .byte_en(byte_en),
    .rd_valid(rd_valid), .rd_dst(rd_dst), .rd_ch(rd_ch), .bus_err(bus_err)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_addr_chan u_chan (
      .clk(clk), .rst_n(rst_n_i),
      .src_we(src_we[i]), .dst_we(dst_we[i]), .byte_en(byte_en), .wdata(bus_wdata),
      .start(ch_start[i]), .err_clr(ch_err_clr[i]),
      .src_sz(ch_src_size[2*i +: 2]), .dst_sz(ch_dst_size[2*i +: 2]),
      .src_q(src_q[i]), .dst_q(dst_q[i]),
      .src_bad(src_bad[i]), .dst_bad(dst_bad[i]),
      .misalign(ch_misalign[i]), .cfg_err(ch_cfg_err[i])
    );
    assign ch_src_addr[ADDR_W*i +: ADDR_W] = src_q[i];
    assign ch_dst_addr[ADDR_W*i +: ADDR_W] = dst_q[i];
  end

  always_comb begin
    rd_word = rd_dst ? dst_q[rd_ch] : src_q[rd_ch];
    rd_bad  = rd_dst ? dst_bad[rd_ch] : src_bad[rd_ch];
    if (!rd_valid)
      bus_rdata = '0;
    else
      bus_rdata = {rd_bad ? {UP_W{1'b0}} : rd_word[ADDR_W-1:UP_LSB], rd_word[UP_LSB-1:0]};
  end
endmodule

// File: rtl/dma_addr_bank_chk.sv
module dma_addr_bank_chk
  import dma_addr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic                     bus_wr,
  input logic [31:0]              bus_addr,
  input logic [1:0]               bus_size,
  input logic [31:0]              bus_rdata,
  input logic                     bus_err,
  input logic [NUM_CH-1:0]        ch_start,
  input logic [NUM_CH-1:0]        ch_err_clr,
  input logic [ADDR_W*NUM_CH-1:0] ch_src_addr,
  input logic [ADDR_W*NUM_CH-1:0] ch_dst_addr,
  input logic [NUM_CH-1:0]        ch_cfg_err
);
  // R3
  dst_narrow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[3:2] == 2'b01 && bus_size != SZ_WORD) |-> bus_err);

  // R3
  dst_narrow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[3:2] == 2'b01 && bus_size != SZ_WORD) |=> $stable(ch_dst_addr));

  // R2
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr[3]) |-> bus_err);

  // R6
  rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_err) |-> region_ok(bus_rdata[31:20]));

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(ch_src_addr) && $stable(ch_dst_addr)));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_err_clr & ~ch_start)) |=> ((ch_cfg_err & $past(ch_err_clr & ~ch_start)) == '0));

  // R7
  err_set_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~ch_start & ~ch_cfg_err)) |=> ((ch_cfg_err & ~$past(ch_cfg_err) & ~$past(ch_start)) == '0));
endmodule

bind dma_addr_bank dma_addr_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .ch_start(ch_start), .ch_err_clr(ch_err_clr),
  .ch_src_addr(ch_src_addr), .ch_dst_addr(ch_dst_addr), .ch_cfg_err(ch_cfg_err)
);

// File: tb/dma_addr_bank_bench.sv
`timescale 1ns/1ps
module dma_addr_bank_bench;
  localparam int NCH = 4;
  localparam logic [31:0] B = 32'h4000_8100;
  localparam int K_BERR = 0, K_RDATA = 1, K_CFG = 2, K_MIS = 3, K_SRC = 4, K_DST = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0] bus_size;
  logic bus_err;
  logic [NCH-1:0] ch_start, ch_err_clr, ch_misalign, ch_cfg_err;
  logic [2*NCH-1:0] ch_src_size, ch_dst_size;
  logic [32*NCH-1:0] ch_src_addr, ch_dst_addr;

  typedef struct {
    int          cyc;
    int          kind;
    int          ch;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  item_t it;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] act;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_addr_bank u_dma_addr_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .ch_start(ch_start), .ch_err_clr(ch_err_clr),
    .ch_src_size(ch_src_size), .ch_dst_size(ch_dst_size),
    .ch_src_addr(ch_src_addr), .ch_dst_addr(ch_dst_addr),
    .ch_misalign(ch_misalign), .ch_cfg_err(ch_cfg_err)
  );

  // monitor: compares every item due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      case (it.kind)
        K_BERR:  act = {31'b0, bus_err};
        K_RDATA: act = bus_rdata;
        K_CFG:   act = {31'b0, ch_cfg_err[it.ch]};
        K_MIS:   act = {31'b0, ch_misalign[it.ch]};
        K_SRC:   act = ch_src_addr[32*it.ch +: 32];
        default: act = ch_dst_addr[32*it.ch +: 32];
      endcase
      checks++;
      if (act !== it.exp || it.cyc != cyc) begin
        errors++;
        $display("FAIL %s kind %0d ch %0d: actual %h expected %h", it.req, it.kind, it.ch, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int kind, int ch, logic [31:0] exp, string req);
    item_t n;
    n.cyc = cyc; n.kind = kind; n.ch = ch; n.exp = exp; n.req = req;
    q.push_back(n);
  endtask

  task automatic idle_inputs();
    bus_sel = 0; bus_wr = 0; ch_start = '0; ch_err_clr = '0;
  endtask

  task automatic bwrite(logic [31:0] a, logic [1:0] sz, logic [31:0] d, logic eerr, string req);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    push(K_BERR, 0, {31'b0, eerr}, req);
    tick();
    idle_inputs();
  endtask

  task automatic bread(logic [31:0] a, logic [31:0] exp, logic eerr, string req);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = 2'd2; bus_wdata = '0;
    push(K_BERR, 0, {31'b0, eerr}, req);
    push(K_RDATA, 0, exp, req);
    tick();
    idle_inputs();
  endtask

  task automatic ctrl(logic [NCH-1:0] s, logic [NCH-1:0] c);
    ch_start = s; ch_err_clr = c;
    tick();
    idle_inputs();
  endtask

  task automatic expect_now(int kind, int ch, logic [31:0] exp, string req);
    push(kind, ch, exp, req);
  endtask

  initial begin
    rst_n = 0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    ch_src_size = '0; ch_dst_size = '0;
    idle_inputs();
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1: reset state
    for (int i = 0; i < NCH; i++) begin
      expect_now(K_SRC, i, 32'h0, "R1");
      expect_now(K_DST, i, 32'h0, "R1");
      expect_now(K_CFG, i, 32'h0, "R1");
    end
    tick();
    bread(B + 32'h20, 32'h0, 0, "R1");

    // R5 / R10: permitted word write to destination ch1
    bwrite(B + 32'h14, 2'd2, 32'h2000_0010, 0, "R5");
    expect_now(K_DST, 1, 32'h2000_0010, "R10");
    bread(B + 32'h14, 32'h2000_0010, 0, "R5");

    // R3: narrow destination writes refused
    bwrite(B + 32'h14, 2'd1, 32'h0000_1234, 1, "R3");
    bwrite(B + 32'h16, 2'd0, 32'h00AB_0000, 1, "R3");
    bread(B + 32'h14, 32'h2000_0010, 0, "R3");

    // R4 / R6: source byte lanes
    bwrite(B, 2'd2, 32'h1FF0_0100, 0, "R4");
    bwrite(B + 32'h2, 2'd0, 32'h00AB_0000, 0, "R4");
    expect_now(K_SRC, 0, 32'h1FAB_0100, "R4");
    bread(B, 32'h000B_0100, 0, "R6");
    bwrite(B + 32'h2, 2'd1, 32'h1FF0_0000, 0, "R4");
    bread(B, 32'h1FF0_0100, 0, "R5");
    bwrite(B + 32'h1, 2'd1, 32'hFFFF_FFFF, 1, "R4");
    bwrite(B, 2'd3, 32'hFFFF_FFFF, 1, "R4");
    bread(B, 32'h1FF0_0100, 0, "R4");

    // R2: map and unmapped slots
    bread(B + 32'h08, 32'h0, 1, "R2");
    bwrite(B + 32'h0C, 2'd2, 32'h2000_0000, 1, "R2");
    bread(32'h4000_8140, 32'h0, 1, "R2");
    bwrite(B + 32'h34, 2'd2, 32'h4000_0000, 0, "R2");
    bread(B + 32'h34, 32'h4000_0000, 0, "R2");
    bread(B + 32'h30, 32'h0, 0, "R2");

    // R6 / R7: bad region accepted, flagged on start
    bwrite(B + 32'h24, 2'd2, 32'h3000_0004, 0, "R6");
    expect_now(K_DST, 2, 32'h3000_0004, "R6");
    bread(B + 32'h24, 32'h0000_0004, 0, "R6");
    expect_now(K_CFG, 2, 32'h0, "R7");
    ctrl(4'b0110, 4'b0000);
    expect_now(K_CFG, 2, 32'h1, "R7");
    expect_now(K_CFG, 1, 32'h0, "R7");
    tick();

    // R9: sticky, clear, start+clear
    expect_now(K_CFG, 2, 32'h1, "R9");
    ctrl(4'b0000, 4'b0100);
    expect_now(K_CFG, 2, 32'h0, "R9");
    ctrl(4'b0100, 4'b0100);
    expect_now(K_CFG, 2, 32'h1, "R9");
    ctrl(4'b0000, 4'b0100);
    expect_now(K_CFG, 2, 32'h0, "R9");
    bwrite(B + 32'h24, 2'd2, 32'h2000_0004, 0, "R7");
    ctrl(4'b0100, 4'b0000);
    expect_now(K_CFG, 2, 32'h0, "R7");
    tick();

    // R8: alignment against programmed sizes
    bwrite(B + 32'h04, 2'd2, 32'h2000_0002, 0, "R8");
    ch_src_size[1:0] = 2'd2; ch_dst_size[1:0] = 2'd2;
    expect_now(K_MIS, 0, 32'h1, "R8");
    tick();
    ch_dst_size[1:0] = 2'd1;
    expect_now(K_MIS, 0, 32'h0, "R8");
    ctrl(4'b0001, 4'b0000);
    expect_now(K_CFG, 0, 32'h0, "R8");
    ch_dst_size[1:0] = 2'd3;
    expect_now(K_MIS, 0, 32'h1, "R8");
    tick();
    ch_dst_size[1:0] = 2'd2;
    ctrl(4'b0001, 4'b0000);
    expect_now(K_CFG, 0, 32'h1, "R8");
    tick();
    bwrite(B + 32'h30, 2'd2, 32'h0000_0003, 0, "R8");
    expect_now(K_MIS, 3, 32'h0, "R8");
    tick();
    ch_src_size[7:6] = 2'd1;
    expect_now(K_MIS, 3, 32'h1, "R8");
    tick();

    repeat (2) tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule